// File: doc/BRIEF.md
# Interrupt Event Queue Writer

This block appends interrupt event records to circular queues kept in a memory. There is one queue for every pairing of a target with a priority. Each queue has a base address, a size given as a power of two number of entries, a write index, and a generation flag.

When a notification is accepted, the block does four things:
- It builds a 32-bit entry with the generation flag in the top bit and a 31-bit logical event number below it.
- It writes the entry at the queue's current slot through a valid/ready memory port.
- It moves the index forward.
- Once the memory has taken the write, it sends a one-cycle notify pulse toward the presenter.

The generation flag inverts every time a queue wraps. A consumer can therefore tell fresh entries from stale ones without sharing a read pointer.

Software-side agents use a configuration port to set up or clear a single queue. A size code of zero turns a queue off, and notifications aimed at a queue that is off are dropped. A flush input returns every queue's index and generation flag to their starting values and leaves base and size alone.

Top module: `event_queue_writer`

## Requirements
- R1: After reset, `mem_valid` and `notify_valid` are low and `ntf_ready` is high. Every queue starts disabled.
- R2: A written entry is `{gen, data}`. Bit 31 is the generation flag and bits 30:0 are the notification's event number.
- R3: The write address is the queue base, with its two low bits forced to zero, plus 4 times the write index. The index advances by one per write and wraps modulo 2^size.
- R4: After configuration or flush, the generation flag of a queue is 1. It inverts on each write that takes the index from its last slot back to zero.
- R5: A notification to a queue whose size code is zero is accepted and dropped. It causes no memory write and no notify pulse.
- R6: In the cycle after a memory handshake (`mem_valid` and `mem_ready` both high), `notify_valid` is high for one cycle. It carries that write's target and priority.
- R7: `flush_all` resets the index to 0 and the generation flag to 1 in every queue. Base and size are kept.
- R8: While `mem_valid` is high and `mem_ready` is low, the address and data are held stable and `ntf_ready` is low. Otherwise `ntf_ready` is high.
- R9: When a notification is accepted in the same cycle as a configuration of its queue or a flush, the write uses the state from before that cycle. The configuration or flush then takes effect.
- R10: A size code above `MAX_LOG2` is treated as `MAX_LOG2`.
- R11: Each queue keeps its own index and generation flag. Writes to one queue do not move another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Apply a queue configuration this cycle |
| cfg_target | input | TGT_W | Target of the queue being configured |
| cfg_prio | input | PRIO_W | Priority of the queue being configured |
| cfg_base | input | ADDR_W | Queue base byte address |
| cfg_size | input | SZ_W | log2 of entry count; 0 disables |
| flush_all | input | 1 | Reset index and generation of all queues |
| ntf_valid | input | 1 | Notification present |
| ntf_ready | output | 1 | Notification accepted when high with ntf_valid |
| ntf_target | input | TGT_W | Notification target |
| ntf_prio | input | PRIO_W | Notification priority |
| ntf_data | input | 31 | Logical event number |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Write byte address |
| mem_wdata | output | 32 | Entry to write |
| notify_valid | output | 1 | One-cycle notify pulse |
| notify_target | output | TGT_W | Target of the notified queue |
| notify_prio | output | PRIO_W | Priority of the notified queue |

## Verification
Three things can land in the same clock: an accepted notification advancing a queue, and a configuration or flush rewinding that same queue. The bench forces this collision on purpose. It then keeps hitting it at random, because configuration and flush commands are mixed into random notification traffic.

The bench judges the result against a behavioural model that applies the advance first and the rewind last. The write issued in that cycle must show the old address and generation flag. The next write to that queue must start at index 0 with the flag set to 1.

A second overlap is also exercised: a memory handshake and the loading of a new entry in the same cycle. The bench drives `mem_ready` in a random pattern to cause it. It then checks that the notify pulse belongs to the entry that drained, not the one just loaded.

// File: rtl/eqw_pkg.sv
package eqw_pkg;
    localparam int ENTRY_W = 32;
    localparam int EDATA_W = ENTRY_W - 1;

    function automatic logic [ENTRY_W-1:0] make_entry(input logic gen,
                                                       input logic [EDATA_W-1:0] evt);
        return {gen, evt};
    endfunction
endpackage

// File: rtl/eqw_queue_table.sv
module eqw_queue_table #(
    parameter int NQ     = 32,
    parameter int QID_W  = 5,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 14,
    parameter int SZ_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              cfg_en,
    input  logic [QID_W-1:0]  cfg_qid,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [SZ_W-1:0]   cfg_size,
    input  logic              adv_en,
    input  logic [QID_W-1:0]  adv_qid,
    input  logic [IDX_W-1:0]  adv_idx,
    input  logic              adv_gen,
    input  logic [QID_W-1:0]  rd_qid,
    output logic [ADDR_W-1:0] rd_base,
    output logic [SZ_W-1:0]   rd_size,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              rd_gen
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [SZ_W-1:0]   size;
        logic [IDX_W-1:0]  idx;
        logic              gen;
    } qstate_t;

    qstate_t view [NQ];

    for (genvar g = 0; g < NQ; g++) begin : g_q
        qstate_t st_d, st_q;

        // advance first, then flush, then configuration: later wins
        always_comb begin
            st_d = st_q;
            if (adv_en && adv_qid == QID_W'(g)) begin
                st_d.idx = adv_idx;
                st_d.gen = adv_gen;
            end
            if (flush) begin
                st_d.idx = '0;
                st_d.gen = 1'b1;
            end
            if (cfg_en && cfg_qid == QID_W'(g)) begin
                st_d.base = cfg_base;
                st_d.size = cfg_size;
                st_d.idx  = '0;
                st_d.gen  = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '{base: '0, size: '0, idx: '0, gen: 1'b1};
            end else begin
                st_q <= st_d;
            end
        end

        assign view[g] = st_q;
    end

    qstate_t rd_sel;
    always_comb begin
        rd_sel = '0;
        if (int'(rd_qid) < NQ) rd_sel = view[rd_qid];
    end

    assign rd_base = rd_sel.base;
    assign rd_size = rd_sel.size;
    assign rd_idx  = rd_sel.idx;
    assign rd_gen  = rd_sel.gen;
endmodule

// File: rtl/eqw_entry_former.sv
module eqw_entry_former
    import eqw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 14,
    parameter int SZ_W   = 4
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [SZ_W-1:0]    size,
    input  logic [IDX_W-1:0]   idx,
    input  logic               gen,
    input  logic [EDATA_W-1:0] evt,
    output logic               enabled,
    output logic [ADDR_W-1:0]  addr,
    output logic [ENTRY_W-1:0] wdata,
    output logic [IDX_W-1:0]   idx_next,
    output logic               gen_next
);
    logic [IDX_W:0]   span;
    logic [IDX_W-1:0] mask;
    logic             wrap;

    always_comb begin
        span     = (IDX_W+1)'(1) << size;
        mask     = span[IDX_W-1:0] - IDX_W'(1);
        wrap     = (idx & mask) == mask;
        enabled  = size != '0;
        addr     = base + ADDR_W'({idx, 2'b00});
        wdata    = make_entry(gen, evt);
        idx_next = wrap ? '0 : idx + IDX_W'(1);
        gen_next = wrap ? ~gen : gen;
    end
endmodule

// File: rtl/eqw_out_stage.sv
module eqw_out_stage #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [31:0]       ld_data,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic              mem_ready,
    output logic              slot_free,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic              nt_valid,
    output logic [TAG_W-1:0]  nt_tag
);
    typedef struct packed {
        logic              mv;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       data;
        logic [TAG_W-1:0]  tag;
        logic              nv;
        logic [TAG_W-1:0]  ntag;
    } ostate_t;

    ostate_t s_d, s_q;
    logic    drain;

    always_comb begin
        s_d   = s_q;
        drain = s_q.mv && mem_ready;
        s_d.nv = drain;
        if (drain) begin
            s_d.ntag = s_q.tag;
            s_d.mv   = 1'b0;
        end
        if (load) begin
            s_d.mv   = 1'b1;
            s_d.addr = ld_addr;
            s_d.data = ld_data;
            s_d.tag  = ld_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign slot_free = !s_q.mv || mem_ready;
    assign mem_valid = s_q.mv;
    assign mem_addr  = s_q.addr;
    assign mem_wdata = s_q.data;
    assign nt_valid  = s_q.nv;
    assign nt_tag    = s_q.ntag;
endmodule

// File: rtl/event_queue_writer.sv
module event_queue_writer
    import eqw_pkg::*;
#(
    parameter int NUM_TARGETS = 4,
    parameter int NUM_PRIOS   = 8,
    parameter int ADDR_W      = 32,
    parameter int MAX_LOG2    = 14,
    localparam int TGT_W  = $clog2(NUM_TARGETS),
    localparam int PRIO_W = $clog2(NUM_PRIOS),
    localparam int SZ_W   = $clog2(MAX_LOG2 + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_valid,
    input  logic [TGT_W-1:0]   cfg_target,
    input  logic [PRIO_W-1:0]  cfg_prio,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [SZ_W-1:0]    cfg_size,
    input  logic               flush_all,
    input  logic               ntf_valid,
    output logic               ntf_ready,
    input  logic [TGT_W-1:0]   ntf_target,
    input  logic [PRIO_W-1:0]  ntf_prio,
    input  logic [EDATA_W-1:0] ntf_data,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [ENTRY_W-1:0] mem_wdata,
    output logic               notify_valid,
    output logic [TGT_W-1:0]   notify_target,
    output logic [PRIO_W-1:0]  notify_prio
);
    localparam int NQ    = NUM_TARGETS * NUM_PRIOS;
    localparam int QID_W = $clog2(NQ);
    localparam int IDX_W = MAX_LOG2;
    localparam int TAG_W = TGT_W + PRIO_W;

    logic [QID_W-1:0]   cfg_qid, ntf_qid;
    logic [SZ_W-1:0]    cfg_size_eff;
    logic [ADDR_W-1:0]  cfg_base_eff;
    logic [ADDR_W-1:0]  q_base;
    logic [SZ_W-1:0]    q_size;
    logic [IDX_W-1:0]   q_idx, q_idx_next;
    logic               q_gen, q_gen_next, q_enabled;
    logic [ADDR_W-1:0]  ent_addr;
    logic [ENTRY_W-1:0] ent_data;
    logic               accept, load;
    logic [TAG_W-1:0]   nt_tag;

    always_comb begin
        cfg_qid      = QID_W'(cfg_target) * QID_W'(NUM_PRIOS) + QID_W'(cfg_prio);
        ntf_qid      = QID_W'(ntf_target) * QID_W'(NUM_PRIOS) + QID_W'(ntf_prio);
        cfg_size_eff = (cfg_size > SZ_W'(MAX_LOG2)) ? SZ_W'(MAX_LOG2) : cfg_size;
        cfg_base_eff = {cfg_base[ADDR_W-1:2], 2'b00};
        accept       = ntf_valid && ntf_ready;
        load         = accept && q_enabled;
    end

    eqw_queue_table #(
        .NQ(NQ), .QID_W(QID_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SZ_W(SZ_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush_all),
        .cfg_en   (cfg_valid),
        .cfg_qid  (cfg_qid),
        .cfg_base (cfg_base_eff),
        .cfg_size (cfg_size_eff),
        .adv_en   (load),
        .adv_qid  (ntf_qid),
        .adv_idx  (q_idx_next),
        .adv_gen  (q_gen_next),
        .rd_qid   (ntf_qid),
        .rd_base  (q_base),
        .rd_size  (q_size),
        .rd_idx   (q_idx),
        .rd_gen   (q_gen)
    );

    eqw_entry_former #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SZ_W(SZ_W)
    ) u_former (
        .base     (q_base),
        .size     (q_size),
        .idx      (q_idx),
        .gen      (q_gen),
        .evt      (ntf_data),
        .enabled  (q_enabled),
        .addr     (ent_addr),
        .wdata    (ent_data),
        .idx_next (q_idx_next),
        .gen_next (q_gen_next)
    );

    eqw_out_stage #(
        .ADDR_W(ADDR_W), .TAG_W(TAG_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ld_addr   (ent_addr),
        .ld_data   (ent_data),
        .ld_tag    ({ntf_target, ntf_prio}),
        .mem_ready (mem_ready),
        .slot_free (ntf_ready),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .nt_valid  (notify_valid),
        .nt_tag    (nt_tag)
    );

    assign notify_target = nt_tag[TAG_W-1:PRIO_W];
    assign notify_prio   = nt_tag[PRIO_W-1:0];
endmodule

// File: rtl/eqw_checks.sv
module eqw_checks #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              ntf_ready,
    input logic              notify_valid
);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata));

    assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |-> !ntf_ready);

    assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready |=> notify_valid);

    assert_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |-> $past(mem_valid && mem_ready));

    assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_addr[1:0] == 2'b00);

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !mem_valid && !notify_valid);
endmodule

bind event_queue_writer eqw_checks #(.ADDR_W(ADDR_W)) u_eqw_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_valid    (mem_valid),
    .mem_ready    (mem_ready),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .ntf_ready    (ntf_ready),
    .notify_valid (notify_valid)
);

// File: tb/tb_event_queue_writer.sv
module tb_event_queue_writer;
    localparam int MAXL = 4;
    localparam int NQ   = 32;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_valid = 0;
    logic [1:0]  cfg_target = 0;
    logic [2:0]  cfg_prio = 0;
    logic [31:0] cfg_base = 0;
    logic [2:0]  cfg_size = 0;
    logic        flush_all = 0;
    logic        ntf_valid = 0;
    logic        ntf_ready;
    logic [1:0]  ntf_target = 0;
    logic [2:0]  ntf_prio = 0;
    logic [30:0] ntf_data = 0;
    logic        mem_valid;
    logic        mem_ready = 1;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        notify_valid;
    logic [1:0]  notify_target;
    logic [2:0]  notify_prio;

    event_queue_writer #(.MAX_LOG2(MAXL)) dut (.*);

    always #10 clk = ~clk;

    int    errs = 0, checks = 0;
    string phase = "R1";
    bit    started = 0, done = 0;

    // behavioural reference
    logic [31:0] m_base [NQ];
    int          m_size [NQ];
    int          m_idx  [NQ];
    logic        m_gen  [NQ];
    logic        m_mval = 0;
    logic [31:0] m_addr, m_data;
    int          m_q, m_nq;
    logic        m_nv = 0;

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            for (int i = 0; i < NQ; i++) begin
                m_base[i] = 0; m_size[i] = 0; m_idx[i] = 0; m_gen[i] = 1;
            end
            m_mval = 0; m_nv = 0;
        end else begin
            automatic bit hs  = m_mval && mem_ready;
            automatic bit acc = ntf_valid && (!m_mval || mem_ready);
            automatic int q   = ntf_target * 8 + ntf_prio;
            m_nv = hs;
            if (hs) begin m_nq = m_q; m_mval = 0; end
            if (acc && m_size[q] != 0) begin
                m_mval = 1;
                m_addr = m_base[q] + 32'(4 * m_idx[q]);
                m_data = {m_gen[q], ntf_data};
                m_q    = q;
                m_idx[q] = (m_idx[q] + 1) % (1 << m_size[q]);
                if (m_idx[q] == 0) m_gen[q] = ~m_gen[q];
            end
            if (flush_all)
                for (int i = 0; i < NQ; i++) begin m_idx[i] = 0; m_gen[i] = 1; end
            if (cfg_valid) begin
                automatic int c = cfg_target * 8 + cfg_prio;
                m_base[c] = cfg_base & ~32'h3;
                m_size[c] = (cfg_size > MAXL) ? MAXL : int'(cfg_size);
                m_idx[c]  = 0;
                m_gen[c]  = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s [%s] %s: actual=%h expected=%h at %0t", req, phase, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk(ntf_ready === (!m_mval || mem_ready), "R8", "ntf_ready", 32'(ntf_ready), 32'(!m_mval || mem_ready));
            chk(mem_valid === m_mval, "R1/R5/R8", "mem_valid", 32'(mem_valid), 32'(m_mval));
            if (m_mval) begin
                chk(mem_addr === m_addr, "R3/R11", "mem_addr", mem_addr, m_addr);
                chk(mem_wdata === m_data, "R2/R4", "mem_wdata", mem_wdata, m_data);
            end
            chk(notify_valid === m_nv, "R6", "notify_valid", 32'(notify_valid), 32'(m_nv));
            if (m_nv)
                chk({notify_target, notify_prio} === 5'(m_nq), "R6", "notify_tag",
                    32'({notify_target, notify_prio}), 32'(m_nq));
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic cfg(input int t, input int p, input logic [31:0] b, input int s);
        cfg_valid = 1; cfg_target = 2'(t); cfg_prio = 3'(p); cfg_base = b; cfg_size = 3'(s);
        cyc();
        cfg_valid = 0;
    endtask

    task automatic post(input int t, input int p, input logic [30:0] d);
        ntf_valid = 1; ntf_target = 2'(t); ntf_prio = 3'(p); ntf_data = d;
        cyc();
        ntf_valid = 0;
    endtask

    logic [31:0] lf = 32'h1D872B41;
    function automatic logic [31:0] step(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    initial begin
        // R1: reset state observed while reset is held and just after release
        repeat (3) cyc();
        rst_n = 1;
        cyc(); cyc();

        // R2 R3 R4 R11: two-entry queue wraps, four-entry queue interleaved
        phase = "R2 R3 R4 R11";
        cfg(0, 0, 32'h0000_1000, 1);
        cfg(1, 3, 32'h0000_2003, 2);
        for (int i = 0; i < 6; i++) begin
            post(0, 0, 31'(32'h100 + i));
            post(1, 3, 31'(32'h7FFF_FF00 + i));
        end
        cyc();

        // R5: disabled queue, plus reconfiguring to zero
        phase = "R5";
        post(3, 7, 31'h55);
        cfg(0, 0, 32'h0000_1000, 0);
        post(0, 0, 31'h66);
        cyc(); cyc();

        // R8 R6: backpressure on the memory port
        phase = "R8 R6";
        mem_ready = 0;
        post(1, 3, 31'h11);
        post(1, 3, 31'h12);
        cyc(); cyc();
        mem_ready = 1;
        post(1, 3, 31'h13);
        mem_ready = 0;
        cyc();
        mem_ready = 1;
        cyc(); cyc();

        // R7: flush keeps base and size, rewinds index and generation
        phase = "R7";
        post(1, 3, 31'h21);
        flush_all = 1; cyc(); flush_all = 0;
        post(1, 3, 31'h22);
        post(1, 3, 31'h23);
        cyc();

        // R9: notification collides with configuration and with flush
        phase = "R9";
        cfg(2, 5, 32'h0000_4000, 2);
        post(2, 5, 31'h31);
        ntf_valid = 1; ntf_target = 2; ntf_prio = 5; ntf_data = 31'h32;
        cfg_valid = 1; cfg_target = 2; cfg_prio = 5; cfg_base = 32'h0000_5000; cfg_size = 1;
        cyc();
        cfg_valid = 0; ntf_data = 31'h33;
        flush_all = 1;
        cyc();
        flush_all = 0; ntf_valid = 0;
        post(2, 5, 31'h34);
        cyc();

        // R10: size code above the maximum is clamped
        phase = "R10";
        cfg(3, 1, 32'h0000_8000, 7);
        for (int i = 0; i < 18; i++) post(3, 1, 31'(i));
        cyc();

        // random mix: every requirement, collisions included
        phase = "R2 R3 R4 R6 R7 R8 R9 R11 random";
        for (int i = 0; i < 600; i++) begin
            lf = step(lf);
            mem_ready  = lf[0] | lf[1];
            ntf_valid  = lf[2] | lf[9];
            ntf_target = lf[4:3];
            ntf_prio   = {lf[6], 2'b00} | 3'(lf[5]);
            ntf_data   = lf[30:0];
            cfg_valid  = lf[15:12] == 0;
            cfg_target = lf[17:16];
            cfg_prio   = {lf[19], 2'b00} | 3'(lf[18]);
            cfg_size   = lf[22:20];
            cfg_base   = {16'h0, lf[29:23], 9'h0};
            flush_all  = lf[31:26] == 0;
            cyc();
        end
        ntf_valid = 0; cfg_valid = 0; flush_all = 0; mem_ready = 1;
        cyc(); cyc();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errs++; checks++;
            $display("FAIL watchdog [%s]: actual=hung expected=finished", phase);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule